// File: doc/BRIEF.md
# Interframe Gap Bit-Time Timer

This block enforces the idle gap, measured in bit times, that a serial link controller leaves between two transmitted frames. The gap length comes from an 8-bit spacing register that a CPU-side port writes. The link framing may be CSMA/CD or SDLC, and the same timer serves both. Only even gaps are possible. The register keeps the written value with its least significant bit dropped, so it holds half of the requested gap. A gap is produced by counting that half value down twice in a row, and each decrement is taken on a bit-time tick strobe.

The link side raises a one-cycle start pulse when a frame finishes. The ready output then falls and stays low until both countdown passes have expired. The next frame may begin once ready is high again. A readback port shows the live pass count in its upper seven bits and a pass flag in bit 0. The flag is 1 during the first pass and 0 during the second. The whole block runs on a single clock, and the tick acts as a clock enable.

Top module: `ifs_gap_timer`

## Requirements
- R1: After reset, gap_ready is 1 and rd_data is 0x00.
- R2: A write stores wr_data[7:1] as the half value H. The write ignores wr_data[0]. A started gap with H > 0 lasts exactly 2*H ticks, counted from the start pulse until gap_ready returns high.
- R3: Take a start pulse with H > 0. In the cycle after the pulse, gap_ready is 0 and rd_data equals {H, 1'b1}.
- R4: During a gap, rd_data changes only in cycles that follow a high bit_tick, a start pulse or a pass change. Each tick lowers the count field, rd_data[7:1], by one.
- R5: On the tick that ends the first pass, the pass flag rd_data[0] goes to 0 and the count reloads to the H stored at that moment.
- R6: On the tick that ends the second pass, gap_ready returns to 1 in the next cycle and rd_data returns to 0x00. While the timer is idle, gap_ready stays 1 and rd_data stays 0x00.
- R7: With a written value of 0 or 1 (H = 0), a start pulse leaves gap_ready high and produces no gap.
- R8: A write made during a gap leaves the running count alone. The new H is used only from the next reload: the second-pass reload or the next start.
- R9: A start pulse that arrives during a gap restarts the first pass. The count goes to H and the flag goes to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both CPU and link sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Spacing register write strobe |
| wr_data | input | 8 | Requested gap in bit times; bit 0 ignored |
| rd_data | output | 8 | {live pass count, pass flag} |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| gap_start | input | 1 | Pulse at end of a transmitted frame |
| gap_ready | output | 1 | High when the next frame may start |

## Verification
The bench sends odd gap values to confirm that the LSB is dropped. A design that used the LSB would make gaps one tick too long. Ticks are spread out with idle cycles between them, because a design that counted clocks instead of ticks would close the gap early. The bench writes new values mid-gap and restarts gaps mid-pass. A design that applied the new value to the running count, or that resumed the old pass on a restart, would move the ready edge away from the predicted cycle. Zero and one as spacing values check that ready never drops, and a design that waited a full counter wrap would stall.

// File: rtl/ifs_pkg.sv
package ifs_pkg;

   typedef struct packed {
      logic clr;
      logic load;
      logic dec;
   } cnt_cmd_t;

   localparam cnt_cmd_t CMD_IDLE = '{clr: 1'b0, load: 1'b0, dec: 1'b0};

endpackage

// File: rtl/ifs_spacing_reg.sv
module ifs_spacing_reg #(
   parameter int CNT_W     = 7,
   parameter int RESET_VAL = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CNT_W:0]   wr_data,
   output logic [CNT_W-1:0] half_q,
   output logic             half_zero
);
   localparam logic [CNT_W-1:0] HALF_RST = CNT_W'(RESET_VAL / 2);

   logic unused_lsb_w;
   assign unused_lsb_w = wr_data[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         half_q <= HALF_RST;
      else if (wr_en)
         half_q <= wr_data[CNT_W:1];
   end

   assign half_zero = (half_q == '0);

   p_write_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (half_q == $past(wr_data[CNT_W:1])));

   p_hold_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(half_q));
endmodule

// File: rtl/ifs_pass_counter.sv
module ifs_pass_counter
   import ifs_pkg::*;
#(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  cnt_cmd_t         cmd,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt_q,
   output logic             at_last
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (cmd.clr)
         cnt_q <= '0;
      else if (cmd.load)
         cnt_q <= load_val;
      else if (cmd.dec && cnt_q != '0)
         cnt_q <= cnt_q - ONE;
   end

   assign at_last = (cnt_q == ONE);

   p_dec_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.dec && !cmd.load && !cmd.clr && cnt_q != '0)
         |=> (cnt_q == CNT_W'($past(cnt_q) - ONE)));

   p_cmd_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({cmd.clr, cmd.load, cmd.dec}) <= 1);
endmodule

// File: rtl/ifs_phase_ctl.sv
module ifs_phase_ctl
   import ifs_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start,
   input  logic     tick,
   input  logic     at_last,
   input  logic     half_zero,
   output cnt_cmd_t cmd,
   output logic     busy_q,
   output logic     phase_q
);
   logic busy_d, phase_d;
   logic pass_end;

   assign pass_end = busy_q && tick && at_last && !start;

   always_comb begin
      busy_d  = busy_q;
      phase_d = phase_q;
      cmd     = CMD_IDLE;
      if (start) begin
         if (half_zero) begin
            busy_d  = 1'b0;
            phase_d = 1'b0;
            cmd.clr = 1'b1;
         end else begin
            busy_d   = 1'b1;
            phase_d  = 1'b1;
            cmd.load = 1'b1;
         end
      end else if (pass_end) begin
         if (phase_q && !half_zero) begin
            phase_d  = 1'b0;
            cmd.load = 1'b1;
         end else begin
            busy_d  = 1'b0;
            phase_d = 1'b0;
            cmd.clr = 1'b1;
         end
      end else if (busy_q && tick) begin
         cmd.dec = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         phase_q <= 1'b0;
      end else begin
         busy_q  <= busy_d;
         phase_q <= phase_d;
      end
   end

   p_idle_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !phase_q);

   p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !half_zero) |=> (busy_q && phase_q));

   p_second_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !phase_q && tick && at_last && !start) |=> !busy_q);
endmodule

// File: rtl/ifs_gap_timer.sv
module ifs_gap_timer
   import ifs_pkg::*;
#(
   parameter int CNT_W     = 7,
   parameter int RESET_VAL = 0,
   parameter bit RD_REG    = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CNT_W:0]   wr_data,
   output logic [CNT_W:0]   rd_data,
   input  logic             bit_tick,
   input  logic             gap_start,
   output logic             gap_ready
);
   localparam int REG_W = CNT_W + 1;

   if (CNT_W < 2)
      $error("ifs_gap_timer: CNT_W must be at least 2");
   if (RESET_VAL < 0 || RESET_VAL >= (1 << REG_W))
      $error("ifs_gap_timer: RESET_VAL does not fit the register");

   logic [CNT_W-1:0] half_q;
   logic             half_zero;
   logic [CNT_W-1:0] cnt_q;
   logic             at_last;
   logic             busy_q;
   logic             phase_q;
   cnt_cmd_t         cmd;
   logic [REG_W-1:0] live_w;

   ifs_spacing_reg #(.CNT_W(CNT_W), .RESET_VAL(RESET_VAL)) u_spacing (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .half_q    (half_q),
      .half_zero (half_zero)
   );

   ifs_phase_ctl u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (gap_start),
      .tick      (bit_tick),
      .at_last   (at_last),
      .half_zero (half_zero),
      .cmd       (cmd),
      .busy_q    (busy_q),
      .phase_q   (phase_q)
   );

   ifs_pass_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd      (cmd),
      .load_val (half_q),
      .cnt_q    (cnt_q),
      .at_last  (at_last)
   );

   assign live_w    = {cnt_q, phase_q};
   assign gap_ready = !busy_q;

   if (RD_REG) begin : g_rd_reg
      logic [REG_W-1:0] rd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rd_q <= '0;
         else
            rd_q <= live_w;
      end
      assign rd_data = rd_q;
   end else begin : g_rd_comb
      assign rd_data = live_w;

      p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
         gap_ready |-> (rd_data == '0));

      p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (!bit_tick && !gap_start) |=> $stable(rd_data));

      p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (gap_start && !half_zero) |=> (!gap_ready && rd_data == {$past(half_q), 1'b1}));

      p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
         ($fell(phase_q) && busy_q) |-> (rd_data[CNT_W:1] == $past(half_q)));
   end

   p_zero_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (gap_start && half_zero) |=> gap_ready);
endmodule

// File: tb/ifs_gap_timer_tb.sv
`timescale 1ns/1ps
module ifs_gap_timer_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       bit_tick = 1'b0;
   logic       gap_start = 1'b0;
   logic       gap_ready;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   // reference state, built from the requirements
   logic       m_busy = 1'b0;
   logic       m_phase = 1'b0;
   logic [6:0] m_cnt = '0;
   logic [6:0] m_half = '0;

   always #2.5 clk = ~clk;

   ifs_gap_timer dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .rd_data   (rd_data),
      .bit_tick  (bit_tick),
      .gap_start (gap_start),
      .gap_ready (gap_ready)
   );

   function automatic int exp_gap(input logic [7:0] v);
      return int'({v[7:1], 1'b0});
   endfunction

   function automatic logic [7:0] exp_rd();
      return {m_cnt, m_phase};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic model_step(input logic t, input logic s, input logic w, input logic [7:0] d);
      if (s) begin
         if (m_half == 0) begin m_busy = 0; m_phase = 0; m_cnt = 0; end
         else begin m_busy = 1; m_phase = 1; m_cnt = m_half; end
      end else if (m_busy && t) begin
         if (m_cnt > 1) m_cnt = m_cnt - 1;
         else if (m_phase && m_half != 0) begin m_phase = 0; m_cnt = m_half; end
         else begin m_busy = 0; m_phase = 0; m_cnt = 0; end
      end
      if (w) m_half = d[7:1];
   endtask

   // called at a negedge; returns at the next negedge
   task automatic cyc(input logic t, input logic s, input logic w, input logic [7:0] d, input string req);
      bit_tick = t; gap_start = s; wr_en = w; wr_data = d;
      @(posedge clk);
      model_step(t, s, w, d);
      @(negedge clk);
      bit_tick = 0; gap_start = 0; wr_en = 0;
      check({req, " rd"}, 32'(rd_data), 32'(exp_rd()));
      check({req, " ready"}, 32'(gap_ready), 32'(!m_busy));
   endtask

   task automatic measure(input logic [7:0] v, input string req);
      int ticks = 0;
      cyc(0, 0, 1, v, req);
      cyc(0, 1, 0, 0, req);
      while (!gap_ready && ticks < 400) begin
         cyc(1, 0, 0, 0, req);
         ticks++;
      end
      check({req, " gap length"}, 32'(ticks), 32'(exp_gap(v)));
   endtask

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 ready", 32'(gap_ready), 32'd1);
      check("R1 rd", 32'(rd_data), 32'h00);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: odd value drops its LSB
      measure(8'd9, "R2");
      measure(8'd2, "R2");
      measure(8'd255, "R2");

      // R3: start loads {H,1}
      cyc(0, 0, 1, 8'd10, "R3");
      cyc(0, 1, 0, 0, "R3");
      check("R3 rd", 32'(rd_data), 32'h0B);
      check("R3 ready", 32'(gap_ready), 32'd0);

      // R4: idle cycles between ticks hold the count
      cyc(0, 0, 0, 0, "R4");
      cyc(0, 0, 0, 0, "R4");
      check("R4 hold", 32'(rd_data), 32'h0B);
      cyc(1, 0, 0, 0, "R4");
      check("R4 dec", 32'(rd_data), 32'h09);

      // R5: first pass expires after 5 ticks total, reload to H
      for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, "R5");
      check("R5 phase", 32'(rd_data), 32'h0A);

      // R6: second pass end
      for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, "R6");
      check("R6 ready", 32'(gap_ready), 32'd1);
      check("R6 rd", 32'(rd_data), 32'h00);

      // R7: values 0 and 1 give no gap
      cyc(0, 0, 1, 8'd1, "R7");
      cyc(0, 1, 0, 0, "R7");
      check("R7 ready v1", 32'(gap_ready), 32'd1);
      cyc(0, 0, 1, 8'd0, "R7");
      cyc(1, 1, 0, 0, "R7");
      check("R7 ready v0", 32'(gap_ready), 32'd1);

      // R8: mid-gap write applies at second-pass reload
      cyc(0, 0, 1, 8'd6, "R8");
      cyc(0, 1, 0, 0, "R8");
      cyc(1, 0, 1, 8'd20, "R8");
      check("R8 running", 32'(rd_data), 32'h05);
      cyc(1, 0, 0, 0, "R8");
      cyc(1, 0, 0, 0, "R8");
      check("R8 reload", 32'(rd_data), 32'h14);

      // R9: restart during second pass
      cyc(1, 0, 0, 0, "R9");
      cyc(1, 1, 0, 0, "R9");
      check("R9 restart", 32'(rd_data), 32'h15);
      while (!gap_ready) cyc(1, 0, 0, 0, "R9");

      // mixed random run against the reference model
      void'($urandom(32'h1F5_0A4));
      for (int i = 0; i < 6000; i++) begin
         logic t, s, w;
         logic [7:0] d;
         t = ($urandom % 3) != 0;
         s = ($urandom % 40) == 0;
         w = ($urandom % 50) == 0;
         d = 8'($urandom % 24);
         cyc(t, s, w, d, "R4");
      end

      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule